// File: doc/BRIEF.md
# Break Address Comparator Bank

This block holds a bank of programmable break entries and compares them with the CPU address bus on every valid bus cycle. Each entry carries an enable flag and an 18-bit tag. The tag is taken from address bits 19 down to 2. An entry therefore selects one 4-byte slot, and that slot is repeated in every 1 MB region, because bits 23 to 20 and 1 to 0 take no part in the compare. When any enabled entry matches a valid bus cycle outside the register window, a registered request pulse goes to the CPU's non-maskable interrupt line.

Software sets up the entries through a 256-byte window at the top of the 24-bit address space, using 8-bit writes and reads. The window starts at FFFF00h. Entry k takes the four bytes starting at FFFF00h + 4k. Reads are combinational from the address, so the read data is valid in the same cycle as the access.

Top module: `brk_cmp_bank`

## Requirements
- R1: After reset every entry is disabled with a zero tag, and `nmi_req_o` is low.
- R2: Each entry has a fixed byte layout within its four bytes, and a write followed by a read returns what was written. Byte 0 holds the enable flag in bit 7 and tag bits A19..A16 in bits 3..0; bits 6..4 read 0. Byte 1 holds A15..A8. Byte 2 holds A7..A2 in bits 7..2; bits 1..0 read 0.
- R3: Byte 3 of every entry ignores writes and reads back 0.
- R4: Window offsets 80h..FFh, which lie beyond the last entry, ignore writes and read back 0. Reads of any address outside the window also return 0.
- R5: A valid bus cycle whose A19..A2 equal the tag of an enabled entry raises `nmi_req_o` on the next clock, for exactly one clock.
- R6: Address bits A23..A20 and A1..A0 do not affect a match.
- R7: An entry whose enable flag is 0 never produces a match.
- R8: No request is raised when `bus_valid_i` is low, or when the bus cycle falls inside the register window.
- R9: Any entry, including the last one (31), can produce the request, and a cycle that matches no enabled entry leaves the request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Marks a valid bus cycle in this clock |
| bus_we_i | input | 1 | Write cycle when high |
| addr_i | input | 24 | CPU address bus |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data from the register window |
| nmi_req_o | output | 1 | Registered break request to the NMI line |

## Verification
The compare path is tested with four kinds of bus address:
- An exact tag hit, which confirms the basic match.
- The same slot with bits 23..20 and 1..0 changed, which separates a correct 18-bit compare from a full-width or shifted one.
- An address one slot away, which confirms that every compared bit is used.
- Matches with the enable flag cleared, with the strobe low, and inside the window, which show that each gating term is applied.

Register readback is run with bit patterns that differ per byte and per entry. A wrong field position, a missing write mask or a write that lands on the wrong entry therefore shows up as a wrong value on `rdata_o`.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int TAG_HI = 19;
  localparam int TAG_LO = 2;
  localparam int TAG_W  = TAG_HI - TAG_LO + 1;

  typedef struct packed {
    logic             en;
    logic [TAG_W-1:0] tag;
  } brk_entry_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int N_ENTRY = 32,
  parameter int AW      = 24
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic                       bus_we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [7:0]                 wdata_i,
  output logic                       win_hit_o,
  output logic [7:0]                 rdata_o,
  output brk_entry_t [N_ENTRY-1:0]   entries_o
);
  localparam int IDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

  logic [5:0]       slot;
  logic [1:0]       bsel;
  logic             in_range;
  logic             wr_ok;
  logic [IDX_W-1:0] ridx;
  brk_entry_t       rent;

  assign slot      = addr_i[7:2];
  assign bsel      = addr_i[1:0];
  assign win_hit_o = &addr_i[AW-1:8];
  assign in_range  = {1'b0, slot} < 7'(N_ENTRY);
  assign wr_ok     = bus_valid_i & bus_we_i & win_hit_o & in_range;
  assign ridx      = slot[IDX_W-1:0];

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entries_o[g] <= '0;
      end else if (wr_ok && slot == 6'(g)) begin
        case (bsel)
          2'd0: begin
            entries_o[g].en                  <= wdata_i[7];
            entries_o[g].tag[TAG_W-1:TAG_W-4] <= wdata_i[3:0];
          end
          2'd1: entries_o[g].tag[TAG_W-5:TAG_W-12] <= wdata_i;
          2'd2: entries_o[g].tag[5:0]              <= wdata_i[7:2];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rent    = entries_o[ridx];
    rdata_o = '0;
    if (win_hit_o && in_range) begin
      case (bsel)
        2'd0:    rdata_o = {rent.en, 3'b000, rent.tag[TAG_W-1:TAG_W-4]};
        2'd1:    rdata_o = rent.tag[TAG_W-5:TAG_W-12];
        2'd2:    rdata_o = {rent.tag[5:0], 2'b00};
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int N_ENTRY = 32
) (
  input  brk_entry_t [N_ENTRY-1:0] entries_i,
  input  logic [TAG_W-1:0]         tag_i,
  output logic                     hit_o
);
  logic [N_ENTRY-1:0] hit_vec;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
    assign hit_vec[g] = entries_i[g].en & (entries_i[g].tag == tag_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/brk_cmp_bank.sv
module brk_cmp_bank
  import brk_pkg::*;
#(
  parameter int N_ENTRY = 32,
  parameter int AW      = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_valid_i,
  input  logic          bus_we_i,
  input  logic [23:0]   addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          nmi_req_o
);
  brk_entry_t [N_ENTRY-1:0] entries;
  logic                     win_hit;
  logic                     any_hit;

  brk_regs #(.N_ENTRY(N_ENTRY), .AW(AW)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_we_i    (bus_we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .win_hit_o   (win_hit),
    .rdata_o     (rdata_o),
    .entries_o   (entries)
  );

  brk_match #(.N_ENTRY(N_ENTRY)) i_match (
    .entries_i (entries),
    .tag_i     (addr_i[TAG_HI:TAG_LO]),
    .hit_o     (any_hit)
  );

  // one registered pulse per matching bus cycle; window cycles never trap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_req_o <= 1'b0;
    else         nmi_req_o <= bus_valid_i & ~win_hit & any_hit;
  end
endmodule

// File: rtl/brk_cmp_chk.sv
module brk_cmp_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_valid_i,
  input logic        bus_we_i,
  input logic [23:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        nmi_req_o
);
  logic in_win;
  assign in_win = &addr_i[23:8];

  AST_REQ_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o |-> $past(bus_valid_i) && !(&$past(addr_i[23:8]))) // R8
    else $error("request without qualifying bus cycle");

  AST_WIN_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && in_win) |=> !nmi_req_o) // R8
    else $error("window access raised request");

  AST_OUTSIDE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |-> rdata_o == 8'h00) // R4
    else $error("read data outside window");

  AST_HIGH_HALF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[7]) |-> rdata_o == 8'h00) // R4
    else $error("upper window half not zero");

  AST_BYTE3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] == 2'b11) |-> rdata_o == 8'h00) // R3
    else $error("reserved byte not zero");

  AST_PAD_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && addr_i[1:0] == 2'b00) |-> rdata_o[6:4] == 3'b000) // R2
    else $error("byte0 pad bits set");

  logic unused_ok;
  assign unused_ok = bus_we_i ^ (|wdata_i);
endmodule

bind brk_cmp_bank brk_cmp_chk i_brk_cmp_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_we_i    (bus_we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .nmi_req_o   (nmi_req_o)
);

// File: tb/test_brk_cmp_bank.sv
module test_brk_cmp_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        nmi_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_q[$];
  string       tag_q[$];
  logic        m_en[32];
  logic [17:0] m_tag[32];

  always #10 clk = ~clk;

  brk_cmp_bank i_brk_cmp_bank (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .nmi_req_o(nmi_req_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected request value per clock
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {7'b0, nmi_req_o}, {7'b0, e});
    end
  end

  function automatic logic model_hit(input logic [23:0] a);
    logic h = 1'b0;
    for (int k = 0; k < 32; k++)
      if (m_en[k] && m_tag[k] == a[19:2]) h = 1'b1;
    return h;
  endfunction

  task automatic cyc(input logic v, input logic we, input logic [23:0] a,
                     input logic [7:0] d, input string req);
    logic e;
    @(negedge clk);
    bus_valid_i = v; bus_we_i = we; addr_i = a; wdata_i = d;
    e = v && (a[23:8] != 16'hFFFF) && model_hit(a);
    exp_q.push_back(e);
    tag_q.push_back(req);
    if (v && we && a[23:8] == 16'hFFFF && a[7] == 1'b0) begin
      case (a[1:0])
        2'd0: begin m_en[a[6:2]] = d[7]; m_tag[a[6:2]][17:14] = d[3:0]; end
        2'd1: m_tag[a[6:2]][13:6] = d;
        2'd2: m_tag[a[6:2]][5:0] = d[7:2];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [23:0] a, input logic [7:0] exp, input string req);
    cyc(1'b1, 1'b0, a, 8'h00, req);
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic set_entry(input int k, input logic en, input logic [23:0] a);
    logic [23:0] b = 24'hFFFF00 + 24'(4 * k);
    cyc(1'b1, 1'b1, b,     {en, 3'b111, a[19:16]}, "R2");
    cyc(1'b1, 1'b1, b + 1, a[15:8], "R2");
    cyc(1'b1, 1'b1, b + 2, {a[7:2], 2'b11}, "R2");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) begin m_en[k] = 0; m_tag[k] = '0; end
    #45;
    check("R1", {7'b0, nmi_req_o}, 8'h00);
    rst_ni = 1'b1;
    // R1: cleared entries
    rd(24'hFFFF00, 8'h00, "R1");
    rd(24'hFFFF7D, 8'h00, "R1");
    // R2: readback layout, pad bits masked
    set_entry(3, 1'b1, 24'h0A5678);
    rd(24'hFFFF0C, 8'h8A, "R2");
    rd(24'hFFFF0D, 8'h56, "R2");
    rd(24'hFFFF0E, 8'h78, "R2");
    set_entry(31, 1'b1, 24'h3C3D4C);
    rd(24'hFFFF7C, 8'h8C, "R2");
    rd(24'hFFFF7D, 8'h3D, "R2");
    rd(24'hFFFF7E, 8'h4C, "R2");
    rd(24'hFFFF10, 8'h00, "R2");
    // R3: byte 3 ignored
    cyc(1'b1, 1'b1, 24'hFFFF0F, 8'hFF, "R3");
    rd(24'hFFFF0F, 8'h00, "R3");
    rd(24'hFFFF0C, 8'h8A, "R3");
    // R4: upper half ignored, outside reads zero
    cyc(1'b1, 1'b1, 24'hFFFF8C, 8'hFF, "R4");
    cyc(1'b1, 1'b1, 24'hFFFF8D, 8'hFF, "R4");
    rd(24'hFFFF8C, 8'h00, "R4");
    rd(24'hFFFF0C, 8'h8A, "R4");
    rd(24'hFFFF0D, 8'h56, "R4");
    rd(24'h00000C, 8'h00, "R4");
    // R5: exact match, single pulse
    cyc(1'b1, 1'b0, 24'h0A5678, 8'h00, "R5");
    cyc(1'b0, 1'b0, 24'h000000, 8'h00, "R5");
    cyc(1'b1, 1'b0, 24'h0A5678, 8'h00, "R5");
    cyc(1'b1, 1'b0, 24'h0A5678, 8'h00, "R5");
    // R6: don't-care bits
    cyc(1'b1, 1'b0, 24'hFA567B, 8'h00, "R6");
    cyc(1'b1, 1'b0, 24'h5A5679, 8'h00, "R6");
    cyc(1'b1, 1'b0, 24'h0A567C, 8'h00, "R6");
    cyc(1'b1, 1'b0, 24'h0B5678, 8'h00, "R6");
    // R9: last entry and a miss
    cyc(1'b1, 1'b0, 24'h7C3D4C, 8'h00, "R9");
    cyc(1'b1, 1'b0, 24'h123454, 8'h00, "R9");
    // R8: strobe low, window cycles
    cyc(1'b0, 1'b0, 24'h0A5678, 8'h00, "R8");
    cyc(1'b1, 1'b0, 24'hFFFF0C, 8'h00, "R8");
    set_entry(5, 1'b1, 24'h0FFF18);
    cyc(1'b1, 1'b0, 24'hFFFF18, 8'h00, "R8");
    cyc(1'b1, 1'b0, 24'h0FFF18, 8'h00, "R8");
    // R7: disable entry 3
    cyc(1'b1, 1'b1, 24'hFFFF0C, 8'h0A, "R7");
    cyc(1'b1, 1'b0, 24'h0A5678, 8'h00, "R7");
    rd(24'hFFFF0C, 8'h0A, "R7");
    cyc(1'b1, 1'b0, 24'h7C3D4C, 8'h00, "R7");
    cyc(1'b0, 1'b0, 24'h000000, 8'h00, "R5");
    cyc(1'b0, 1'b0, 24'h000000, 8'h00, "R5");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule